// File: doc/BRIEF.md
# Preloadable Bit-Timing Counter

This block is an up counter with a reload value, meant to pace individual serial bits for a UART driven by software, or to count pulses on a pin. Software programs a reload value and picks one of four count sources. When it writes the counter register, the counter is loaded from the reload value. Each time the counter wraps past its top value, it reloads itself and produces a carry. That carry samples the receive pin into a receive latch, moves the next transmit bit onto the transmit output, and sets a sticky interrupt flag.

An optional start detector holds the counter while the receive line idles high. It releases the counter on the first falling edge of that line, then disarms itself, so the first interval is timed from the start edge. Software does the framing, the shifting of whole characters and the choice of reload values.

The block runs on one system clock. The auxiliary clock and the external pin are sampled as levels, and their rising edges become count ticks. The block has no data stream with flow control. All pins are plain control and status signals, and a register write always takes effect in the cycle it is presented.

Top module: `bit_timer`

## Requirements
- R1: Control bits [1:0] select the count source: 0 counts every system clock cycle, 1 counts each rising edge of `aux_clk`, 2 counts each rising edge of `ext_pin`, and 3 counts every system clock cycle in which `ext_pin` is high.
- R2: Any write to the counter register (address 1) loads the counter with the reload register (address 0), whatever the write data, and takes priority over counting in the same cycle.
- R3: The reload register can be rewritten after the counter has been loaded without changing the counter. The new value is used at the next load or wrap.
- R4: While `cnt_en` is high, the counter advances by one on each tick of the selected source. While `cnt_en` is low, it holds.
- R5: While start detection is armed (control bit 2 reads 1), the counter does not advance.
- R6: A falling edge on `rx_in` while armed clears the arm bit, and counting resumes from the next cycle. Writing control bit 2 as 1 re-arms the detector.
- R7: On a wrap, the receive latch takes the level of `rx_in` and the transmit latch (`tx_out`) takes the pending transmit bit (data register bit 0 when written). Data register reads return {pending bit, tx latch, rx latch} in bits [2:0].
- R8: A wrap happens on a tick while the counter holds all ones. On a wrap, the counter reloads from the reload register and the interrupt flag (control bit 7, `irq`) is set.
- R9: Writing the control register with bit 7 set clears the interrupt flag. Writing it with bit 7 clear leaves the flag unchanged, and a wrap in the same cycle wins over the clear.
- R10: A synchronous active-high reset clears the counter, reload register, control register, flag and receive latch, and sets the transmit latch and pending transmit bit to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 reload, 1 counter, 2 control, 3 data |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the addressed register |
| cnt_en | input | 1 | Count enable |
| aux_clk | input | 1 | Auxiliary clock level, sampled |
| ext_pin | input | 1 | External count pin level, sampled |
| rx_in | input | 1 | Receive line |
| tx_out | output | 1 | Transmit latch output |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The counter is tested with runs of back-to-back ticks, with enable patterns that switch on and off at random, with sparse edges on the auxiliary clock and the pin, and with a gated pattern in which the pin level matters but its edges do not. Comparing the edge-counting modes against the gated mode exposes mixed-up source decoding. Random reload values over long runs test the wrap arithmetic and the reload. Directed wraps with both receive and transmit levels show whether the latches follow the carry or the reset value. A start-detect sequence with the line held idle shows whether gating and self-disarm are in place.

// File: rtl/bit_timer_pkg.sv
package bit_timer_pkg;
  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_AUX   = 2'd1,
    SRC_PIN   = 2'd2,
    SRC_GATED = 2'd3
  } src_sel_e;

  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_DATA   = 2'd3;

  localparam int CTRL_ARM_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 7;
endpackage

// File: rtl/bt_tick_gen.sv
module bt_tick_gen
  import bit_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_sel_e sel,
  input  logic     aux_clk,
  input  logic     ext_pin,
  output logic     tick
);
  logic aux_q, pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      aux_q <= aux_clk;
      pin_q <= ext_pin;
    end
  end

  always_comb begin
    unique case (sel)
      SRC_SYS:   tick = 1'b1;
      SRC_AUX:   tick = aux_clk & ~aux_q;
      SRC_PIN:   tick = ext_pin & ~pin_q;
      SRC_GATED: tick = ext_pin;
      default:   tick = 1'b0;
    endcase
  end

  // R1: an edge mode never ticks twice in a row
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_PIN && tick) |=> (sel != SRC_PIN || !tick));
endmodule

// File: rtl/bt_start_gate.sv
module bt_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic arm_val,
  input  logic rx_in,
  output logic armed
);
  logic rx_q;
  logic fall;

  assign fall = rx_q & ~rx_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= 1'b1;
      armed <= 1'b0;
    end else begin
      rx_q <= rx_in;
      if (ctrl_wr)
        armed <= arm_val;
      else if (armed && fall)
        armed <= 1'b0;
    end
  end

  // R6: the detector disarms on a falling receive edge
  assert_disarm_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && fall && !ctrl_wr) |=> !armed);
  // R6: without a falling edge or a write, the armed state holds
  assert_hold_arm_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && !fall && !ctrl_wr) |=> armed);
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [WIDTH-1:0] reload,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  assign carry = tick && !load && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load || carry)
      count <= reload;
    else if (tick)
      count <= count + 1'b1;
  end

  // R2: a load takes the reload value
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(reload));
  // R4: a tick below the top value advances by one
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  // R8: a wrap reloads
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    carry |=> count == $past(reload));
endmodule

// File: rtl/bit_timer.sv
module bit_timer
  import bit_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             cnt_en,
  input  logic             aux_clk,
  input  logic             ext_pin,
  input  logic             rx_in,
  output logic             tx_out,
  output logic             irq
);
  logic [WIDTH-1:0] reload_q;
  logic [WIDTH-1:0] count;
  src_sel_e         sel_q;
  logic             flag_q, tx_next_q, rx_lat_q, tx_lat_q;
  logic             src_tick, armed, carry, cnt_load, ctrl_wr, tick;

  assign ctrl_wr  = bus_wr && bus_addr == ADDR_CTRL;
  assign cnt_load = bus_wr && bus_addr == ADDR_COUNT;
  assign tick     = src_tick && cnt_en && !armed;

  bt_tick_gen u_tick (
    .clk(clk), .rst(rst), .sel(sel_q),
    .aux_clk(aux_clk), .ext_pin(ext_pin), .tick(src_tick)
  );

  bt_start_gate u_start (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
    .arm_val(bus_wdata[CTRL_ARM_BIT]), .rx_in(rx_in), .armed(armed)
  );

  bt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load),
    .reload(reload_q), .count(count), .carry(carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      sel_q     <= SRC_SYS;
      flag_q    <= 1'b0;
      tx_next_q <= 1'b1;
      rx_lat_q  <= 1'b0;
      tx_lat_q  <= 1'b1;
    end else begin
      if (bus_wr && bus_addr == ADDR_RELOAD) reload_q <= bus_wdata;
      if (ctrl_wr) sel_q <= src_sel_e'(bus_wdata[1:0]);
      if (bus_wr && bus_addr == ADDR_DATA) tx_next_q <= bus_wdata[0];
      if (carry)
        flag_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[CTRL_FLAG_BIT])
        flag_q <= 1'b0;
      if (carry) begin
        rx_lat_q <= rx_in;
        tx_lat_q <= tx_next_q;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_RELOAD: bus_rdata = reload_q;
      ADDR_COUNT:  bus_rdata = count;
      ADDR_CTRL: begin
        bus_rdata[1:0]           = sel_q;
        bus_rdata[CTRL_ARM_BIT]  = armed;
        bus_rdata[CTRL_FLAG_BIT] = flag_q;
      end
      default: bus_rdata[2:0] = {tx_next_q, tx_lat_q, rx_lat_q};
    endcase
  end

  assign tx_out = tx_lat_q;
  assign irq    = flag_q;

  // R5: while armed the counter only changes by a load
  assert_armed_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !cnt_load) |=> count == $past(count));
  // R7: the transmit output follows the pending bit on a wrap
  assert_tx_carry_R7: assert property (@(posedge clk) disable iff (rst)
    carry |=> tx_out == $past(tx_next_q));
  // R8: a wrap raises the interrupt
  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    carry |=> irq);
  // R9: the flag never falls without a clearing control write
  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctrl_wr && bus_wdata[CTRL_FLAG_BIT])) |=> irq);
endmodule

// File: tb/tb_bit_timer.sv
module tb_bit_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0, aux_clk = 1'b0, ext_pin = 1'b0, rx_in = 1'b1;
  logic       tx_out, irq;
  int compared = 0, mismatched = 0, cycles = 0;

  always #2 clk = ~clk;

  bit_timer #(.WIDTH(8)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_en(cnt_en),
    .aux_clk(aux_clk), .ext_pin(ext_pin), .rx_in(rx_in),
    .tx_out(tx_out), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    compared = compared + 1;
    if (act != exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected counter value after n ticks from a load of p
  function automatic int exp_count(input int p, input int n);
    return p + (n % (256 - p));
  endfunction

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) step();
    rst = 1'b0;
    // reset state
    rd(2'd1, v); check("R10 count", v, 0);
    rd(2'd0, v); check("R10 reload", v, 0);
    rd(2'd2, v); check("R10 ctrl", v, 0);
    rd(2'd3, v); check("R10 data", v, 8'h06);
    check("R10 tx_out", tx_out, 1);
    check("R10 irq", irq, 0);

    // load and count on system clock
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R2 load", v, 8'hF0);
    wr(2'd0, 8'h20);
    rd(2'd1, v); check("R3 reload buffered", v, 8'hF0);
    cnt_en = 1'b1; repeat (7) step(); cnt_en = 1'b0;
    repeat (3) step();
    rd(2'd1, v); check("R4 seven ticks then hold", v, 8'hF7);

    // wrap with rx low, pending tx 0
    wr(2'd0, 8'hFC); wr(2'd1, 8'h00);
    wr(2'd3, 8'h00);
    rx_in = 1'b0;
    cnt_en = 1'b1; repeat (4) step(); cnt_en = 1'b0;
    rd(2'd1, v); check("R8 reload on wrap", v, 8'hFC);
    check("R8 irq", irq, 1);
    check("R7 tx_out", tx_out, 0);
    rd(2'd3, v); check("R7 data latches", v, 8'h00);
    wr(2'd2, 8'h00);
    check("R9 no clear without bit7", irq, 1);
    wr(2'd2, 8'h80);
    check("R9 clear", irq, 0);

    // wrap with rx high, pending tx 1
    rx_in = 1'b1;
    wr(2'd3, 8'h01); wr(2'd0, 8'hFE); wr(2'd1, 8'h00);
    cnt_en = 1'b1; repeat (2) step(); cnt_en = 1'b0;
    rd(2'd3, v); check("R7 data latches high", v, 8'h07);
    check("R7 tx_out high", tx_out, 1);
    // clear racing a wrap: set wins
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    wr(2'd2, 8'h80);
    cnt_en = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h80; bus_wr = 1'b1;
    step(); bus_wr = 1'b0; cnt_en = 1'b0;
    check("R9 set wins over clear", irq, 1);
    wr(2'd2, 8'h80);

    // aux clock source
    wr(2'd0, 8'h10); wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    aux_clk = 1'b0; step();
    cnt_en = 1'b1;
    for (int i = 0; i < 6; i++) begin aux_clk = (i % 2 == 0); step(); end
    cnt_en = 1'b0;
    rd(2'd1, v); check("R1 aux edges", v, 8'h13);
    // pin edge source
    wr(2'd1, 8'h00); wr(2'd2, 8'h02);
    ext_pin = 1'b0; step();
    cnt_en = 1'b1;
    for (int i = 0; i < 6; i++) begin ext_pin = (i < 3); step(); end
    cnt_en = 1'b0;
    rd(2'd1, v); check("R1 pin edges", v, 8'h11);
    // gated source: pin levels 1,0,1,1,0
    wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    cnt_en = 1'b1;
    for (int i = 0; i < 5; i++) begin ext_pin = (i != 1 && i != 4); step(); end
    cnt_en = 1'b0; ext_pin = 1'b0;
    rd(2'd1, v); check("R1 gated", v, 8'h13);

    // start detection
    wr(2'd1, 8'h00); wr(2'd2, 8'h04);
    rd(2'd2, v); check("R6 armed", v, 8'h04);
    rx_in = 1'b1; cnt_en = 1'b1;
    repeat (5) step();
    rd(2'd1, v); check("R5 held while armed", v, 8'h10);
    rx_in = 1'b0; step();
    repeat (3) step();
    cnt_en = 1'b0;
    rd(2'd1, v); check("R6 counts after edge", v, 8'h13);
    rd(2'd2, v); check("R6 disarmed", v, 8'h00);
    rx_in = 1'b1;

    // random runs on system clock
    for (int it = 0; it < 40; it++) begin
      int p, n, ticks;
      p = $urandom_range(255, 100);
      n = $urandom_range(300, 1);
      ticks = 0;
      wr(2'd2, 8'h80);
      wr(2'd0, p[7:0]); wr(2'd1, 8'h00);
      for (int c = 0; c < n; c++) begin
        cnt_en = $urandom_range(1, 0);
        if (cnt_en) ticks++;
        step();
      end
      cnt_en = 1'b0;
      rd(2'd1, v); check("R4 random count", v, exp_count(p, ticks));
      check("R8 random flag", irq, (ticks >= 256 - p) ? 1 : 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule